// File: doc/BRIEF.md
# Time-of-Day Format Timer Counter

This block is a 32-bit timer whose count can be held in one of two forms. It can be a plain binary number, or it can be a packed time of day. The packed form has an hours field, a minutes field, a seconds field and a field of 1/128-second ticks. A prescaler divides pulses from a reference strobe. With a 32,768 Hz reference and a divide ratio of 256, the tick field steps 128 times per second. Each packed field rolls over at its own limit and carries into (or borrows from) the next field. The block can count up or down.

Software uses four word addresses:
- a load register;
- a read-only current-value register;
- a control register;
- a clear register, where any write drops the pending interrupt.

The interrupt is raised when a down count reaches zero or an up count reaches full scale. It stays high until it is cleared.

Top module: `tod_timer`

## Requirements
- R1: After reset the value, load and control registers read 0 and `irq` is low.
- R2: While enabled, the count takes one step for every PRESCALE cycles on which `refTick` is high. After PRESCALE-1 such cycles the value is unchanged.
- R3: While the enable bit (control bit 0) is 0, `refTick` has no effect on the value. A write to the value address (1) never changes it.
- R4: With the format field (control bits 5:4) not equal to 01, the count is binary. Counting up (control bit 1 = 1) adds 1 and wraps from FFFFFFFF to 0. Counting down subtracts 1 and wraps from 0 to FFFFFFFF.
- R5: With format 01 the value is packed in fields: hours in bits 31:24, minutes in 21:16, seconds in 13:8 and ticks in 6:0. Counting up, ticks wrap from 127 to 0 and carry into seconds. Seconds and minutes each wrap from 59 to 0 and carry onward. Hours wrap from their maximum to 0.
- R6: With format 01, counting down from a zero field borrows from the next field up. The zero field reloads at its maximum: 127 for ticks, 59 for seconds and minutes, and the hour maximum for hours.
- R7: Control bit 2 = 1 limits hours to 0..23. With it at 0, hours run 0..255.
- R8: With format 01, bits 23:22, 15:14 and 7 read as 0 in the load readback and in the value. Control bits other than 0, 1, 2, 5 and 4 read as 0.
- R9: `irq` rises on the clock edge of a count step whose new value is 0 (counting down) or full scale (counting up). Full scale is FFFFFFFF in binary, or hour-max:59:59:127 in format 01. `irq` then stays high.
- R10: Any write to the clear address (3) drops `irq` at the next edge. A count step that sets `irq` on that same edge wins.
- R11: A load written while the block is disabled reaches the value two edges after the write. A load written while enabled replaces the next count step instead. A loading step never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | Reference strobe, one pulse per reference period |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 load, 1 value, 2 control, 3 clear |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read address, same map |
| rdData | output | 32 | Combinational read data |
| irq | output | 1 | Sticky interrupt |

## Verification
The bench builds the block with PRESCALE = 4, so one packed tick costs four reference pulses. This makes near-exhaustive runs affordable: 8000 consecutive steps up from zero and 8000 steps down from one hour each pass through more than a minute of seconds and minute carries. Short runs loaded just below the hour limit, or just above zero, reach the 23-hour and 255-hour wraps, the borrows and the interrupt edges. Binary mode, prescale counting, gating and deferred loads are probed with directed steps.

// File: rtl/tod_timer_pkg.sv
package tod_timer_pkg;

  localparam int unsigned DATA_W = 32;

  localparam logic [31:0] TOD_MASK = 32'hFF3F_3F7F;
  localparam logic [7:0]  TCK_MAX  = 8'd127;
  localparam logic [7:0]  SEC_MAX  = 8'd59;
  localparam logic [7:0]  MIN_MAX  = 8'd59;
  localparam logic [7:0]  HR_MAX_DAY  = 8'd23;
  localparam logic [7:0]  HR_MAX_WIDE = 8'd255;

  localparam logic [1:0] FMT_TOD = 2'b01;

  typedef enum logic [1:0] {
    ADDR_LOAD  = 2'd0,
    ADDR_VALUE = 2'd1,
    ADDR_CTRL  = 2'd2,
    ADDR_CLEAR = 2'd3
  } addr_e;

  typedef struct packed {
    logic [1:0] fmt;
    logic       hr24;
    logic       up;
    logic       en;
  } ctrl_t;

  // strobes from control to datapath
  typedef struct packed {
    logic step;
    logic load;
    logic up;
    logic tod;
    logic hr24;
  } strobe_t;

  function automatic logic [31:0] ctrlWord(ctrl_t c);
    return {26'd0, c.fmt, 1'b0, c.hr24, c.up, c.en};
  endfunction

  // one packed field: {carry, newValue}
  function automatic logic [8:0] fieldStep(logic [7:0] v, logic [7:0] maxV,
                                           logic up, logic cin);
    if (!cin) return {1'b0, v};
    if (up) return (v >= maxV) ? {1'b1, 8'd0} : {1'b0, v + 8'd1};
    return (v == 8'd0) ? {1'b1, maxV} : {1'b0, v - 8'd1};
  endfunction

endpackage

// File: rtl/tod_timer_ctrl.sv
module tod_timer_ctrl
  import tod_timer_pkg::*;
#(
  parameter int unsigned PRESCALE = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refTick,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic        hit,
  output strobe_t     stb,
  output logic [31:0] loadView,
  output logic [31:0] ctrlView,
  output logic        irq
);

  ctrl_t       ctrlQ;
  logic [31:0] loadQ;
  logic        pendQ;
  logic        tick;
  logic        loadStb;
  logic        wrLoad;
  logic        wrCtrl;
  logic        wrClear;
  logic        tod;

  assign wrLoad  = wrEn && (wrAddr == ADDR_LOAD);
  assign wrCtrl  = wrEn && (wrAddr == ADDR_CTRL);
  assign wrClear = wrEn && (wrAddr == ADDR_CLEAR);
  assign tod     = (ctrlQ.fmt == FMT_TOD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      loadQ <= '0;
    end else begin
      if (wrCtrl) begin
        ctrlQ.en   <= wrData[0];
        ctrlQ.up   <= wrData[1];
        ctrlQ.hr24 <= wrData[2];
        ctrlQ.fmt  <= wrData[5:4];
      end
      if (wrLoad) loadQ <= wrData;
    end
  end

  // prescaler: variant chosen by the divide ratio
  generate
    if (PRESCALE <= 1) begin : g_noDiv
      assign tick = ctrlQ.en && refTick;
    end else begin : g_div
      localparam int unsigned PS_W = $clog2(PRESCALE);
      localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
      logic [PS_W-1:0] psCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !ctrlQ.en) psCnt <= '0;
        else if (refTick) psCnt <= (psCnt == PS_LAST) ? '0 : psCnt + 1'b1;
      end
      assign tick = ctrlQ.en && refTick && (psCnt == PS_LAST);
    end
  endgenerate

  assign loadStb = pendQ && (tick || !ctrlQ.en);

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= 1'b0;
    else if (wrLoad) pendQ <= 1'b1;
    else if (loadStb) pendQ <= 1'b0;
  end

  always_comb begin
    stb.step = tick && !loadStb;
    stb.load = loadStb;
    stb.up   = ctrlQ.up;
    stb.tod  = tod;
    stb.hr24 = ctrlQ.hr24;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else if (stb.step && hit) irq <= 1'b1;
    else if (wrClear) irq <= 1'b0;
  end

  assign loadView = tod ? (loadQ & TOD_MASK) : loadQ;
  assign ctrlView = ctrlWord(ctrlQ);

endmodule

// File: rtl/tod_timer_dp.sv
module tod_timer_dp
  import tod_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [31:0] loadVal,
  output logic [31:0] cnt,
  output logic        hit
);

  logic [31:0] binNext;
  logic [31:0] todNext;
  logic [31:0] nextVal;
  logic [31:0] fullScale;
  logic [7:0]  hrMax;
  logic [8:0]  fTck, fSec, fMin, fHr;

  assign hrMax   = stb.hr24 ? HR_MAX_DAY : HR_MAX_WIDE;
  assign binNext = stb.up ? cnt + 32'd1 : cnt - 32'd1;

  always_comb begin
    fTck = fieldStep({1'b0, cnt[6:0]},   TCK_MAX, stb.up, 1'b1);
    fSec = fieldStep({2'b0, cnt[13:8]},  SEC_MAX, stb.up, fTck[8]);
    fMin = fieldStep({2'b0, cnt[21:16]}, MIN_MAX, stb.up, fSec[8]);
    fHr  = fieldStep(cnt[31:24],         hrMax,   stb.up, fMin[8]);
    todNext = {fHr[7:0], 2'b00, fMin[5:0], 2'b00, fSec[5:0], 1'b0, fTck[6:0]};
  end

  assign nextVal   = stb.tod ? todNext : binNext;
  assign fullScale = stb.tod ? {hrMax, 2'b00, MIN_MAX[5:0], 2'b00, SEC_MAX[5:0], 1'b0, TCK_MAX[6:0]}
                             : 32'hFFFF_FFFF;
  assign hit = stb.up ? (nextVal == fullScale) : (nextVal == 32'd0);

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (stb.load) cnt <= stb.tod ? (loadVal & TOD_MASK) : loadVal;
    else if (stb.step) cnt <= nextVal;
  end

endmodule

// File: rtl/tod_timer.sv
module tod_timer
  import tod_timer_pkg::*;
#(
  parameter int unsigned PRESCALE = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refTick,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [1:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        irq
);

  strobe_t     stb;
  logic [31:0] loadView;
  logic [31:0] ctrlView;
  logic [31:0] cnt;
  logic        hit;
  logic        stepStb;
  logic        loadStb;
  logic        todMode;
  logic        hr24Mode;
  logic        enMode;

  tod_timer_ctrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .refTick(refTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hit(hit), .stb(stb), .loadView(loadView), .ctrlView(ctrlView), .irq(irq)
  );

  tod_timer_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal(loadView), .cnt(cnt), .hit(hit)
  );

  assign stepStb  = stb.step;
  assign loadStb  = stb.load;
  assign todMode  = stb.tod;
  assign hr24Mode = stb.hr24;
  assign enMode   = ctrlView[0];

  always_comb begin
    unique case (rdAddr)
      ADDR_LOAD:  rdData = loadView;
      ADDR_VALUE: rdData = cnt;
      ADDR_CTRL:  rdData = ctrlView;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/tod_timer_chk.sv
module tod_timer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        irq,
  input logic        wrEn,
  input logic [1:0]  wrAddr,
  input logic        stepStb,
  input logic        loadStb,
  input logic        enMode,
  input logic        todMode,
  input logic        hr24Mode,
  input logic [31:0] cnt
);

  a_r2_no_step_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enMode |-> !stepStb);

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!enMode && !loadStb) |=> $stable(cnt));

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(wrEn && wrAddr == 2'd3)) |=> irq);

  a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd3 && !stepStb) |=> !irq);

  a_r8_gaps_zero: assert property (@(posedge clk) disable iff (!rstN)
    (todMode && (stepStb || loadStb)) |=> ((cnt & 32'h00C0_C080) == 32'd0));

  a_r7_hour_cap: assert property (@(posedge clk) disable iff (!rstN)
    (stepStb && todMode && hr24Mode && cnt[31:24] <= 8'd23) |=> (cnt[31:24] <= 8'd23));

  a_r11_load_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !irq) |=> !irq);

endmodule

bind tod_timer tod_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .irq(irq), .wrEn(wrEn), .wrAddr(wrAddr),
  .stepStb(stepStb), .loadStb(loadStb), .enMode(enMode),
  .todMode(todMode), .hr24Mode(hr24Mode), .cnt(cnt)
);

// File: tb/tod_timer_tb.sv
module tod_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PRE = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irq;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  logic [31:0] expVal;
  bit          expIrq;

  tod_timer #(.PRESCALE(PRE)) u_dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  function automatic logic [31:0] ctl(bit en, bit up, bit hr24, logic [1:0] fmt);
    return {26'd0, fmt, 1'b0, hr24, up, en};
  endfunction

  function automatic logic [31:0] tod(int h, int m, int s, int t);
    return {h[7:0], 2'b00, m[5:0], 2'b00, s[5:0], 1'b0, t[6:0]};
  endfunction

  function automatic longint todTotal(logic [31:0] v);
    return ((longint'(v[31:24]) * 60 + v[21:16]) * 60 + v[13:8]) * 128 + v[6:0];
  endfunction

  function automatic logic [31:0] todEncode(longint tot);
    int t, s, m, h;
    t = int'(tot % 128); tot = tot / 128;
    s = int'(tot % 60);  tot = tot / 60;
    m = int'(tot % 60);  h = int'(tot / 60);
    return tod(h, m, s, t);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic busWrite(logic [1:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadIdle(logic [31:0] d);
    busWrite(2'd0, d);
    @(negedge clk);
  endtask

  task automatic refPulses(int n);
    refTick = 1'b1;
    repeat (n) @(negedge clk);
    refTick = 1'b0;
  endtask

  task automatic clearIrq();
    busWrite(2'd3, 32'hA5);
  endtask

  // one count step, check value and interrupt against the model
  task automatic stepCheck(string req, bit isTod, bit up, bit hr24);
    logic [31:0] v;
    longint md, tot;
    bit h;
    if (isTod) begin
      md = (hr24 ? 24 : 256) * 460800;
      tot = todTotal(expVal);
      tot = up ? (tot + 1) % md : (tot + md - 1) % md;
      expVal = todEncode(tot);
      h = up ? (tot == md - 1) : (tot == 0);
    end else begin
      expVal = up ? expVal + 1 : expVal - 1;
      h = up ? (expVal == 32'hFFFF_FFFF) : (expVal == 0);
    end
    if (h) expIrq = 1;
    refPulses(PRE);
    rd(2'd1, v);
    check(req, v, expVal);
    check({req, " R9 irq"}, {31'd0, irq}, {31'd0, expIrq});
    if (irq) begin
      clearIrq();
      expIrq = 0;
      check("R10 clear", {31'd0, irq}, 32'd0);
    end
  endtask

  task automatic sweep(string req, logic [31:0] start, int n, bit up, bit hr24);
    busWrite(2'd2, ctl(0, up, hr24, 2'b01));
    loadIdle(start);
    clearIrq();
    expIrq = 0;
    expVal = start;
    busWrite(2'd2, ctl(1, up, hr24, 2'b01));
    for (int i = 0; i < n; i++) stepCheck(req, 1, up, hr24);
  endtask

  initial begin
    logic [31:0] v, hold;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd1, v); check("R1 value", v, 0);
    rd(2'd0, v); check("R1 load", v, 0);
    rd(2'd2, v); check("R1 ctrl", v, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // R8 reserved control bits
    busWrite(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R8 ctrl reserved", v, 32'h37);
    busWrite(2'd2, ctl(0, 1, 1, 2'b01));
    busWrite(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R8 load gaps", v, 32'hFF3F_3F7F);

    // R4 binary down through zero
    busWrite(2'd2, ctl(0, 0, 0, 2'b00));
    loadIdle(32'd2);
    rd(2'd1, v); check("R11 idle load", v, 2);
    expVal = 2; expIrq = 0;
    busWrite(2'd2, ctl(1, 0, 0, 2'b00));
    for (int i = 0; i < 3; i++) stepCheck("R4 down", 0, 0, 0);

    // R4 binary up through full scale
    busWrite(2'd2, ctl(0, 1, 0, 2'b00));
    loadIdle(32'hFFFF_FFFE);
    expVal = 32'hFFFF_FFFE;
    busWrite(2'd2, ctl(1, 1, 0, 2'b00));
    for (int i = 0; i < 2; i++) stepCheck("R4 up", 0, 1, 0);

    // R2 prescale count
    rd(2'd1, hold);
    refPulses(PRE - 1);
    rd(2'd1, v); check("R2 partial", v, hold);
    refPulses(1);
    rd(2'd1, v); check("R2 full", v, hold + 1);

    // R3 disabled and value-write ignored
    busWrite(2'd2, ctl(0, 1, 0, 2'b00));
    rd(2'd1, hold);
    refPulses(3 * PRE);
    rd(2'd1, v); check("R3 gated", v, hold);
    busWrite(2'd1, 32'h1234_5678);
    @(negedge clk);
    rd(2'd1, v); check("R3 value write", v, hold);

    // R11 deferred load while enabled
    busWrite(2'd2, ctl(0, 1, 1, 2'b01));
    loadIdle(tod(1, 2, 3, 4));
    clearIrq();
    busWrite(2'd2, ctl(1, 1, 1, 2'b01));
    busWrite(2'd0, tod(5, 30, 42, 16));
    @(negedge clk);
    rd(2'd1, v); check("R11 deferred hold", v, tod(1, 2, 3, 4));
    refPulses(PRE);
    rd(2'd1, v); check("R11 deferred apply", v, tod(5, 30, 42, 16));
    check("R11 no irq", {31'd0, irq}, 0);

    // R5 long up sweep, R7/R9 day wrap
    sweep("R5 up sweep", 32'd0, 8000, 1, 1);
    sweep("R7 day wrap", tod(23, 59, 59, 100), 40, 1, 1);
    // R6 borrows
    sweep("R6 down sweep", tod(1, 0, 0, 50), 8000, 0, 1);
    sweep("R6 down wrap", tod(0, 0, 0, 5), 10, 0, 1);
    // R7 wide hours
    sweep("R7 wide pass", tod(23, 59, 59, 126), 4, 1, 0);
    sweep("R7 wide wrap", tod(255, 59, 59, 125), 5, 1, 0);
    sweep("R7 wide down", tod(0, 0, 0, 1), 3, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule